// File: doc/BRIEF.md
# Serial Port Mode Control and DMA Request Gating

This block holds the byte-wide mode control register of a serial port and the small amount of logic that the register drives directly. Software writes the register over a simple write/read port. The register selects synchronous or asynchronous framing. It arms multiprocessor address (attention) mode, which hardware disarms when an address frame arrives. It can force a line break on the transmit output. In synchronous mode it chooses whether the serial clock pin is driven from the internal baud clock or sampled as an external clock. It also enables the two DMA request lines.

The shift engines and the baud generator sit outside the block. The receiver pulses a frame-done strobe and presents the ninth bit of that frame. The transmitter hands over its raw serial data, and the block returns the line value with any forced break applied. Both buffer status flags come in, and the DMA requests go out as the AND of each flag and its enable bit.

Top module: `usart_mode_ctl`

## Requirements
- R1: A synchronous active-high reset clears the register to 0x00, so that rd_data is 0, sclk_oe is 0 and both DMA requests are 0.
- R2: A write with wr_en high loads wr_data bits 5:0 on the next clock edge. Bits 7:6 always read 0 and ignore writes. With no write and no address frame, the register holds its value.
- R3: Bit 0 selects the mode (0 asynchronous, 1 synchronous), and the sync_mode output reflects it.
- R4: Bit 1 arms attention mode and drives attn_mode. A cycle with rx_frame_done high and rx_ninth_bit high clears bit 1 on the next edge. A frame whose ninth bit is 0 leaves bit 1 unchanged.
- R5: When a write and an address-frame clear land in the same cycle, bit 1 becomes 0. The other bits still take the written values.
- R6: While bit 2 (break) is 1, txd is 0. While bit 2 is 0, txd equals tx_data_raw.
- R7: sclk_oe is 1 only when bit 0 is 1 and bit 3 is 0. In that case sclk_out equals baud_clk. Otherwise sclk_out is 0.
- R8: shift_clk equals sclk_in when bit 0 is 1 and bit 3 is 1, and equals baud_clk in every other case. Bit 3 has no effect in asynchronous mode.
- R9: dma_tx_req equals bit 4 AND tx_buf_empty, combinationally, in the same cycle as the flag.
- R10: dma_rx_req equals bit 5 AND rx_buf_full, combinationally, in the same cycle as the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| rx_frame_done | input | 1 | One-cycle strobe when a received frame completes |
| rx_ninth_bit | input | 1 | Ninth bit of the frame just completed |
| tx_buf_empty | input | 1 | Transmit buffer empty flag |
| rx_buf_full | input | 1 | Receive buffer full flag |
| tx_data_raw | input | 1 | Serial data from the transmit shifter |
| baud_clk | input | 1 | Internal baud-rate clock |
| sclk_in | input | 1 | Serial clock pin, input side |
| sclk_out | output | 1 | Serial clock pin, output side |
| sclk_oe | output | 1 | Serial clock pin output enable |
| shift_clk | output | 1 | Selected clock for the shift engines |
| txd | output | 1 | Transmit line after break override |
| sync_mode | output | 1 | Synchronous mode selected |
| attn_mode | output | 1 | Attention mode armed |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The properties assume that rx_frame_done is a clean strobe sampled at the clock edge and that every input is stable around that edge. baud_clk and sclk_in are treated as ordinary data levels that the mux passes through, not as clocks of their own. The stimulus changes every input only at the falling edge and includes writes that collide with address frames. The pin clocks are random bits, so every combination of mode and clock-select bits is covered against both pin levels.

// File: rtl/usart_mode_pkg.sv
package usart_mode_pkg;
  localparam int REG_W     = 8;
  localparam int BIT_MODE  = 0;
  localparam int BIT_ATTN  = 1;
  localparam int BIT_BRK   = 2;
  localparam int BIT_CKS   = 3;
  localparam int BIT_TXDMA = 4;
  localparam int BIT_RXDMA = 5;
  localparam logic [REG_W-1:0] LIVE_MASK = 8'h3F;
endpackage

// File: rtl/umc_ctrl_reg.sv
module umc_ctrl_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] MASK = '1,
  parameter int CLR_BIT = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         hw_clr,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (wr_en) nxt = wr_data & MASK;
    // hardware disarm takes priority over a same-cycle write
    if (hw_clr) nxt[CLR_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/umc_clk_route.sv
module umc_clk_route (
  input  logic sync_mode,
  input  logic ext_sel,
  input  logic baud_clk,
  input  logic sclk_in,
  output logic sclk_out,
  output logic sclk_oe,
  output logic shift_clk
);
  logic use_ext;

  always_comb begin
    use_ext   = sync_mode & ext_sel;
    sclk_oe   = sync_mode & ~ext_sel;
    sclk_out  = sclk_oe & baud_clk;
    shift_clk = use_ext ? sclk_in : baud_clk;
  end
endmodule

// File: rtl/umc_dma_gate.sv
module umc_dma_gate #(
  parameter int N = 2
) (
  input  logic [N-1:0] en,
  input  logic [N-1:0] flag,
  output logic [N-1:0] req
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    assign req[i] = en[i] & flag[i];
  end
endmodule

// File: rtl/usart_mode_ctl.sv
module usart_mode_ctl
  import usart_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             rx_frame_done,
  input  logic             rx_ninth_bit,
  input  logic             tx_buf_empty,
  input  logic             rx_buf_full,
  input  logic             tx_data_raw,
  input  logic             baud_clk,
  input  logic             sclk_in,
  output logic             sclk_out,
  output logic             sclk_oe,
  output logic             shift_clk,
  output logic             txd,
  output logic             sync_mode,
  output logic             attn_mode,
  output logic             dma_tx_req,
  output logic             dma_rx_req
);
  localparam int N_DMA = 2;

  logic [REG_W-1:0] ctl_q;
  logic             addr_hit;
  logic [N_DMA-1:0] dma_en, dma_flag, dma_req;

  assign addr_hit = rx_frame_done & rx_ninth_bit;

  umc_ctrl_reg #(.W(REG_W), .MASK(LIVE_MASK), .CLR_BIT(BIT_ATTN)) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .hw_clr(addr_hit), .q(ctl_q)
  );

  umc_clk_route u_clk (
    .sync_mode(ctl_q[BIT_MODE]), .ext_sel(ctl_q[BIT_CKS]),
    .baud_clk(baud_clk), .sclk_in(sclk_in),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe), .shift_clk(shift_clk)
  );

  assign dma_en   = {ctl_q[BIT_RXDMA], ctl_q[BIT_TXDMA]};
  assign dma_flag = {rx_buf_full, tx_buf_empty};

  umc_dma_gate #(.N(N_DMA)) u_dma (.en(dma_en), .flag(dma_flag), .req(dma_req));

  assign dma_tx_req = dma_req[0];
  assign dma_rx_req = dma_req[1];
  assign txd        = tx_data_raw & ~ctl_q[BIT_BRK];
  assign sync_mode  = ctl_q[BIT_MODE];
  assign attn_mode  = ctl_q[BIT_ATTN];
  assign rd_data    = ctl_q;
endmodule

// File: rtl/usart_mode_ctl_chk.sv
module usart_mode_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       rx_frame_done,
  input logic       rx_ninth_bit,
  input logic       tx_buf_empty,
  input logic       rx_buf_full,
  input logic       txd,
  input logic       sclk_oe,
  input logic       dma_tx_req,
  input logic       dma_rx_req
);
  p_reset_r1: assert property (@(posedge clk) rst |=> rd_data == 8'h00);
  p_write_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rd_data[5:2] == $past(wr_data[5:2])) && (rd_data[0] == $past(wr_data[0])) && (rd_data[7:6] == 2'b00));
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !(rx_frame_done && rx_ninth_bit)) |=> $stable(rd_data));
  // R5 collisions are covered as well: the clear holds whether or not a write lands
  p_attn_clr_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_frame_done && rx_ninth_bit) |=> !rd_data[1]);
  p_break_r6: assert property (@(posedge clk) disable iff (rst) rd_data[2] |-> !txd);
  p_pin_dir_r7: assert property (@(posedge clk) disable iff (rst)
    sclk_oe |-> (rd_data[0] && !rd_data[3]));
  p_txdma_r9: assert property (@(posedge clk) disable iff (rst)
    dma_tx_req == (rd_data[4] && tx_buf_empty));
  p_rxdma_r10: assert property (@(posedge clk) disable iff (rst)
    dma_rx_req == (rd_data[5] && rx_buf_full));
endmodule

bind usart_mode_ctl usart_mode_ctl_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .rx_frame_done(rx_frame_done), .rx_ninth_bit(rx_ninth_bit),
  .tx_buf_empty(tx_buf_empty), .rx_buf_full(rx_buf_full), .txd(txd),
  .sclk_oe(sclk_oe), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
);

// File: tb/tb_usart_mode_ctl.sv
module tb_usart_mode_ctl;
  logic clk = 0;
  logic rst = 1;
  logic wr_en = 0;
  logic [7:0] wr_data = 0;
  logic rx_frame_done = 0, rx_ninth_bit = 0, tx_buf_empty = 0, rx_buf_full = 0;
  logic tx_data_raw = 0, baud_clk = 0, sclk_in = 0;
  logic [7:0] rd_data;
  logic sclk_out, sclk_oe, shift_clk, txd, sync_mode, attn_mode, dma_tx_req, dma_rx_req;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int model = 0;

  always #5 clk = ~clk;

  usart_mode_ctl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .rx_frame_done(rx_frame_done), .rx_ninth_bit(rx_ninth_bit),
    .tx_buf_empty(tx_buf_empty), .rx_buf_full(rx_buf_full), .tx_data_raw(tx_data_raw),
    .baud_clk(baud_clk), .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .shift_clk(shift_clk), .txd(txd), .sync_mode(sync_mode), .attn_mode(attn_mode),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare every output against the model state
  task automatic compare_all();
    bit m0, m2, m3;
    m0 = model[0]; m2 = model[2]; m3 = model[3];
    chk("R2 rd_data", int'(rd_data), model);
    chk("R3 sync_mode", int'(sync_mode), int'(m0));
    chk("R4 attn_mode", int'(attn_mode), int'(model[1]));
    chk("R6 txd", int'(txd), m2 ? 0 : int'(tx_data_raw));
    chk("R7 sclk_oe", int'(sclk_oe), int'(m0 && !m3));
    chk("R7 sclk_out", int'(sclk_out), (m0 && !m3) ? int'(baud_clk) : 0);
    chk("R8 shift_clk", int'(shift_clk), (m0 && m3) ? int'(sclk_in) : int'(baud_clk));
    chk("R9 dma_tx_req", int'(dma_tx_req), int'(model[4] && tx_buf_empty));
    chk("R10 dma_rx_req", int'(dma_rx_req), int'(model[5] && rx_buf_full));
  endtask

  // advance one edge and update the model
  task automatic tick();
    @(posedge clk);
    if (rst) model = 0;
    else begin
      if (wr_en) model = int'(wr_data) & 'h3F;
      if (rx_frame_done && rx_ninth_bit) model = model & ~2;
    end
    @(negedge clk);
  endtask

  task automatic drive(input bit w, input logic [7:0] d, input bit fd, input bit n9);
    wr_en = w; wr_data = d; rx_frame_done = fd; rx_ninth_bit = n9;
  endtask

  initial begin
    @(negedge clk);
    tick(); tick();
    // R1: reset state
    #1 compare_all();
    chk("R1 rd_data after reset", int'(rd_data), 0);
    rst = 0;
    // R2: reserved bits masked
    drive(1, 8'hFF, 0, 0); tick(); drive(0, 0, 0, 0); #1;
    chk("R2 reserved bits read 0", int'(rd_data), 'h3F);
    compare_all();
    // R4: frame with ninth bit 0 leaves attention armed
    drive(1, 8'h02, 0, 0); tick();
    drive(0, 0, 1, 0); tick(); drive(0, 0, 0, 0); #1;
    chk("R4 non-address frame keeps attn", int'(attn_mode), 1);
    // R4: address frame clears it
    drive(0, 0, 1, 1); tick(); drive(0, 0, 0, 0); #1;
    chk("R4 address frame clears attn", int'(attn_mode), 0);
    // R5: collision, clear wins, others written
    drive(1, 8'h13, 1, 1); tick(); drive(0, 0, 0, 0); #1;
    chk("R5 collision result", int'(rd_data), 'h11);
    // R6: break forces low
    drive(1, 8'h04, 0, 0); tick(); drive(0, 0, 0, 0); tx_data_raw = 1; #1;
    chk("R6 break holds txd low", int'(txd), 0);
    drive(1, 8'h00, 0, 0); tick(); drive(0, 0, 0, 0); #1;
    chk("R6 txd follows data after break", int'(txd), 1);
    // R8: ext select ignored in async
    drive(1, 8'h08, 0, 0); tick(); drive(0, 0, 0, 0);
    baud_clk = 1; sclk_in = 0; #1;
    chk("R8 async ignores clock select", int'(shift_clk), 1);
    chk("R7 async pin is input", int'(sclk_oe), 0);
    // R9/R10: same-cycle deassert
    drive(1, 8'h30, 0, 0); tick(); drive(0, 0, 0, 0);
    tx_buf_empty = 1; rx_buf_full = 1; #1;
    chk("R9 tx request", int'(dma_tx_req), 1);
    chk("R10 rx request", int'(dma_rx_req), 1);
    tx_buf_empty = 0; rx_buf_full = 0; #1;
    chk("R9 tx request drops with flag", int'(dma_tx_req), 0);
    chk("R10 rx request drops with flag", int'(dma_rx_req), 0);
    // random traffic compared every cycle
    for (int i = 0; i < 3000; i++) begin
      rst           = ($urandom_range(0, 199) == 0);
      wr_en         = ($urandom_range(0, 3) == 0);
      wr_data       = 8'($urandom);
      rx_frame_done = ($urandom_range(0, 4) == 0);
      rx_ninth_bit  = 1'($urandom);
      tx_buf_empty  = 1'($urandom);
      rx_buf_full   = 1'($urandom);
      tx_data_raw   = 1'($urandom);
      baud_clk      = 1'($urandom);
      sclk_in       = 1'($urandom);
      #1 compare_all();
      tick();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule